// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block is the receive-side character store of a 16550-style serial port. The deserializer hands it one character per push strobe, along with three condition bits for that character: framing error, parity error and break. The processor read path removes the oldest entry with a pop strobe. The oldest character and its condition bits are always visible at the head outputs, together with the current fill count.

Besides the storage, the block keeps two line-status bits. The data-ready bit tells software that received data is waiting. The overrun bit records that a character arrived while the queue was full and had to be dropped.

A push and a pop can land in the same clock cycle, and at high line rates this happens often. The block treats that case as a plain exchange:
- both pointers advance;
- the new entry keeps its condition bits;
- overrun is not raised;
- data-ready stays set even when the only stored entry is the one being read.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 16 entries in arrival order. `headChar` shows the oldest stored character, and `fillCount` shows the number of stored entries.
- R2: Each entry keeps its condition bits with its character. `headFrame`, `headParity` and `headBreak` show the framing-error, parity-error and break bits that were pushed with the head character.
- R3: A push and a pop in the same cycle on a non-empty queue remove the head, append the new entry with its condition bits unaltered, and leave `fillCount` unchanged.
- R4: A push without a pop while 16 entries are stored drops the incoming entry. `fillCount` and the stored contents stay the same.
- R5: `overrun` becomes 1 in the cycle after a push that had no pop in the same cycle and found `fillCount` equal to 16. No other push sets it, including a push paired with a pop on a full queue.
- R6: `overrun` returns to 0 in the cycle after `fifoClr` or `statusClr` is high. A clear wins over a set in the same cycle.
- R7: `dataReady` becomes 1 one cycle after `fillCount` goes from zero to non-zero. It then stays 1 until one of the clear conditions of R8 or R9 occurs.
- R8: `dataReady` clears only when a pop without a push occurs while `fillCount` is 1. When a pop and a push occur together at `fillCount` 1, `dataReady` stays 1.
- R9: `rxRst` clears `dataReady` in the next cycle. It does not change `fillCount`.
- R10: A pop while the queue is empty, with no push in that cycle, leaves `fillCount` at 0.
- R11: `fifoClr` empties the queue in one cycle and returns both pointers to the same slot. The next character pushed afterwards appears at `headChar`.
- R12: After an asynchronous active-low reset, `fillCount`, `dataReady` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Append the character and condition bits on this cycle |
| pushChar | input | 8 | Received character |
| pushFrame | input | 1 | Framing error of the pushed character |
| pushParity | input | 1 | Parity error of the pushed character |
| pushBreak | input | 1 | Break condition of the pushed character |
| popEn | input | 1 | Remove the head entry on this cycle |
| fifoClr | input | 1 | Empty the queue and clear overrun |
| rxRst | input | 1 | Receiver reset; clears data-ready |
| statusClr | input | 1 | Status-read reset; clears overrun |
| headChar | output | 8 | Oldest stored character |
| headFrame | output | 1 | Framing error of the head entry |
| headParity | output | 1 | Parity error of the head entry |
| headBreak | output | 1 | Break condition of the head entry |
| fillCount | output | 5 | Number of stored entries, 0 to 16 |
| dataReady | output | 1 | Line-status data-ready bit |
| overrun | output | 1 | Line-status overrun bit |

## Verification
The hardest situation to reach from the ports is a simultaneous push and pop at the two extreme fill levels: exactly one stored entry, where data-ready must survive, and a full queue, where overrun must not be raised. The bench sweeps every fill level from 0 to 16. At each level it fills the queue with characters and condition bits derived from a sequence number, performs one combined push-and-pop, and then drains the queue while comparing every head entry against that sequence. This places the combined operation at both boundaries, and the condition bits of every entry are checked after the exchange.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int RXQ_CHAR_W = 8;

  typedef struct packed {
    logic                  brk;
    logic                  parityErr;
    logic                  frameErr;
    logic [RXQ_CHAR_W-1:0] char;
  } rxEntry_t;

  typedef struct packed {
    logic wrEn;
    logic rdAdv;
    logic clr;
  } rxqStrobe_t;

endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxqStrobe_t strb,
  input  rxEntry_t   wrData,
  output rxEntry_t   headData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn)  wrPtr <= nextPtr(wrPtr);
      if (strb.rdAdv) rdPtr <= nextPtr(rdPtr);
    end
  end

  // Entries are only ever written by a push; a pop never touches storage.
  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];

  // R3 / R2: a written slot holds exactly the pushed entry afterwards
  p_entry_intact_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> mem[$past(wrPtr)] == $past(wrData));

  // R11: a clear returns both pointers to slot zero
  p_clr_ptrs_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (rdPtr == '0) && (wrPtr == '0));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pushEn,
  input  logic                          popEn,
  input  logic                          fifoClr,
  input  logic                          rxRst,
  input  logic                          statusClr,
  output rxqStrobe_t                    strb,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          dataReady,
  output logic                          overrun
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic isFull;
  logic isEmpty;
  logic doPush;
  logic doPop;
  logic notEmptyD;
  logic readyClear;
  logic readyRise;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);

  // A pop on a full queue frees a slot, so a paired push is accepted.
  assign doPop  = popEn & ~isEmpty & ~fifoClr;
  assign doPush = pushEn & (~isFull | doPop) & ~fifoClr;

  always_comb begin
    strb       = '0;
    strb.wrEn  = doPush;
    strb.rdAdv = doPop;
    strb.clr   = fifoClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (fifoClr) begin
      count <= '0;
    end else begin
      unique case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Overrun: only an unpaired push against a full queue.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       overrun <= 1'b0;
    else if (fifoClr || statusClr)   overrun <= 1'b0;
    else if (pushEn && !popEn && isFull) overrun <= 1'b1;
  end

  // Data-ready: sticky, set on rise of not-empty.
  assign readyClear = ((count == ONE_CNT) && popEn && !pushEn) || rxRst;
  assign readyRise  = ~isEmpty & ~notEmptyD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      notEmptyD <= 1'b0;
      dataReady <= 1'b0;
    end else begin
      notEmptyD <= ~isEmpty;
      if (readyClear) dataReady <= 1'b0;
      else            dataReady <= dataReady | readyRise;
    end
  end

  // R1: occupancy never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R3: combined push and pop on a non-empty queue keeps the count
  p_both_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn && !isEmpty && !fifoClr) |=> count == $past(count));

  // R4: an unpaired push on a full queue keeps the queue full
  p_full_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && isFull && !fifoClr) |=> count == FULL_CNT);

  // R5: overrun only rises after an unpaired push on a full queue
  p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(pushEn && !popEn && isFull));

  // R6: either clear source drops overrun
  p_overrun_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoClr || statusClr) |=> !overrun);

  // R8: a paired push and pop never drops data-ready
  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && pushEn && popEn && !rxRst) |=> dataReady);

  // R9: receiver reset drops data-ready
  p_rxrst_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxRst |=> !dataReady);

  // R10: popping an empty queue leaves it empty
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && isEmpty && !fifoClr) |=> count == '0);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushEn,
  input  logic [RXQ_CHAR_W-1:0]      pushChar,
  input  logic                       pushFrame,
  input  logic                       pushParity,
  input  logic                       pushBreak,
  input  logic                       popEn,
  input  logic                       fifoClr,
  input  logic                       rxRst,
  input  logic                       statusClr,
  output logic [RXQ_CHAR_W-1:0]      headChar,
  output logic                       headFrame,
  output logic                       headParity,
  output logic                       headBreak,
  output logic [$clog2(DEPTH+1)-1:0] fillCount,
  output logic                       dataReady,
  output logic                       overrun
);

  rxqStrobe_t strb;
  rxEntry_t   wrData;
  rxEntry_t   headData;

  always_comb begin
    wrData.char      = pushChar;
    wrData.frameErr  = pushFrame;
    wrData.parityErr = pushParity;
    wrData.brk       = pushBreak;
  end

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (pushEn),
    .popEn     (popEn),
    .fifoClr   (fifoClr),
    .rxRst     (rxRst),
    .statusClr (statusClr),
    .strb      (strb),
    .count     (fillCount),
    .dataReady (dataReady),
    .overrun   (overrun)
  );

  rxq_data #(.DEPTH(DEPTH)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .headData (headData)
  );

  assign headChar   = headData.char;
  assign headFrame  = headData.frameErr;
  assign headParity = headData.parityErr;
  assign headBreak  = headData.brk;

endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushEn = 1'b0, popEn = 1'b0, fifoClr = 1'b0, rxRst = 1'b0, statusClr = 1'b0;
  logic [7:0] pushChar = '0;
  logic       pushFrame = 1'b0, pushParity = 1'b0, pushBreak = 1'b0;
  logic [7:0] headChar;
  logic       headFrame, headParity, headBreak;
  logic [4:0] fillCount;
  logic       dataReady, overrun;

  int nChecks = 0;
  int nFails  = 0;
  int pushSeq = 0;
  int popSeq  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rxq_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushChar(pushChar),
    .pushFrame(pushFrame), .pushParity(pushParity), .pushBreak(pushBreak),
    .popEn(popEn), .fifoClr(fifoClr), .rxRst(rxRst), .statusClr(statusClr),
    .headChar(headChar), .headFrame(headFrame), .headParity(headParity),
    .headBreak(headBreak), .fillCount(fillCount), .dataReady(dataReady),
    .overrun(overrun)
  );

  // Expected entry for sequence number s: {break, parity, frame, char}
  function automatic int entryOf(input int s);
    int ch;
    ch = (s * 37 + 11) % 256;
    return ((s % 8) << 8) | ch;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic chkHead(input string req);
    chk(req, int'({headBreak, headParity, headFrame, headChar}), entryOf(popSeq));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // Called at a falling edge; applies inputs for one rising edge and
  // returns at the following falling edge.
  task automatic cyc(input bit pu, input bit po, input bit fc, input bit rr, input bit sc);
    int e;
    e = entryOf(pushSeq);
    pushEn     = pu;
    popEn      = po;
    fifoClr    = fc;
    rxRst      = rr;
    statusClr  = sc;
    pushChar   = e[7:0];
    pushFrame  = e[8];
    pushParity = e[9];
    pushBreak  = e[10];
    @(negedge clk);
    pushEn = 0; popEn = 0; fifoClr = 0; rxRst = 0; statusClr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 count", int'(fillCount), 0);
    chk("R12 dataReady", int'(dataReady), 0);
    chk("R12 overrun", int'(overrun), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int n = 0; n <= DEPTH; n++) begin
      cyc(0, 0, 1, 0, 0);
      popSeq = pushSeq;
      for (int k = 0; k < n; k++) begin
        cyc(1, 0, 0, 0, 0);
        pushSeq++;
      end
      cyc(0, 0, 0, 0, 0);
      chk("R1 count after fill", int'(fillCount), n);
      chk("R7 dataReady after fill", int'(dataReady), (n > 0) ? 1 : 0);
      chk("R5 no overrun below full", int'(overrun), 0);
      if (n > 0) chkHead("R1 head after fill");

      if (n == DEPTH) begin
        cyc(1, 0, 0, 0, 0);              // dropped push
        chk("R4 count stays full", int'(fillCount), DEPTH);
        chk("R5 overrun on full push", int'(overrun), 1);
        chkHead("R4 head unchanged");
        cyc(0, 0, 0, 0, 1);
        chk("R6 statusClr clears overrun", int'(overrun), 0);
      end

      if (n > 0) begin
        cyc(1, 1, 0, 0, 0);              // r3_ exchange
        pushSeq++;
        popSeq++;
        chk("R3 count kept on push+pop", int'(fillCount), n);
        chk("R8 dataReady kept on push+pop", int'(dataReady), 1);
        chk("R5 no overrun on paired push", int'(overrun), 0);
        cyc(0, 0, 0, 0, 0);
        chk("R8 dataReady still set", int'(dataReady), 1);
      end

      for (int k = 0; k < n; k++) begin
        chkHead("R2 head entry in order");
        cyc(0, 1, 0, 0, 0);
        popSeq++;
        chk("R1 count during drain", int'(fillCount), n - 1 - k);
      end
      chk("R8 dataReady after last pop", int'(dataReady), 0);

      cyc(0, 1, 0, 0, 0);
      chk("R10 pop on empty", int'(fillCount), 0);
    end

    // R6 / R11: fifoClr on a full, overrun queue
    for (int k = 0; k < DEPTH; k++) begin
      cyc(1, 0, 0, 0, 0);
      pushSeq++;
    end
    cyc(1, 0, 0, 0, 0);
    chk("R5 overrun set again", int'(overrun), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R6 fifoClr clears overrun", int'(overrun), 0);
    chk("R11 fifoClr empties", int'(fillCount), 0);
    popSeq = pushSeq;
    cyc(1, 0, 0, 0, 0);
    pushSeq++;
    cyc(0, 0, 0, 0, 0);
    chk("R11 count after refill", int'(fillCount), 1);
    chkHead("R11 head after clear");

    // R9: receiver reset drops data-ready only
    chk("R7 dataReady before rxRst", int'(dataReady), 1);
    cyc(0, 0, 0, 1, 0);
    chk("R9 dataReady cleared", int'(dataReady), 0);
    chk("R9 count unchanged", int'(fillCount), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R9 dataReady stays clear", int'(dataReady), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule